// File: doc/BRIEF.md
# Clock Ratio Enable Generator

This block runs on one fast base clock and derives three clock-enable strobes from it: one for the core domain, one for the bus domain and one for the peripheral domain. Logic in each domain stays on the base clock and advances only in cycles where its strobe is high, so no derived physical clock exists. A 16-bit control word, written through a plain register write port, picks a divide ratio for each domain from a fixed table that includes the non-binary ratios 3, 5 and 6. A prescale bit can add a further divide by six in front of all three domains.

Every accepted write restarts all phase counters together, so after reprogramming the three strobes begin from a common known phase. The block also puts out the total divide that currently applies to the peripheral domain. It raises a one-cycle notice when a write changes that total, so that rate-dependent logic downstream, such as baud generators or timers, can recompute.

Top module: `clkratio_gen`

## Requirements
- R1: After reset, `ctrl_q` reads 0x0E0A and every phase counter is zero. That value gives a core strobe in every cycle, a bus strobe in every second cycle and a peripheral strobe in every fourth cycle, with the first bus strobe in the second cycle after reset and the first peripheral strobe in the fourth.
- R2: When `wr_en` is high and `wr_addr` equals `CTRL_ADDR` (default 0), all 16 bits of `wr_data` are stored and appear on `ctrl_q` from that edge on. A write to any other address changes neither `ctrl_q` nor any strobe phase.
- R3: Bits [8:6] set the core ratio. Codes 0 to 4 give ratios 1 to 5, and codes 5, 6 and 7 give 8.
- R4: Bits [5:3] set the bus ratio, using the same code-to-ratio map as R3.
- R5: Bits [2:0] set the peripheral ratio. Codes 0, 1, 2 and 3 give 2, 3, 4 and 6, and codes 4 to 7 give 8.
- R6: Bit 10 is the fast-mode bit. When it is clear, the period of every strobe is six times its ratio. When it is set, the period equals the ratio.
- R7: Each strobe is high for one base cycle in each period P. In the cycle after an accepted write all three strobes are low. Their first pulses then start at the P-th edge after the write edge and repeat every P cycles after that.
- R8: `per_chg` is high for exactly the cycle after an accepted write, and only when that write changes the total peripheral divide given in R9.
- R9: `per_div` shows the total peripheral divide, that is the peripheral ratio times six when bit 10 is clear. It follows the stored control word with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | 16 | Register write data |
| ctrl_q | output | 16 | Stored control word |
| core_en | output | 1 | Core-domain clock enable |
| bus_en | output | 1 | Bus-domain clock enable |
| per_en | output | 1 | Peripheral-domain clock enable |
| per_div | output | 6 | Total peripheral divide (prescale times ratio) |
| per_chg | output | 1 | One-cycle notice that the peripheral divide changed |

## Verification
If a phase counter or the prescaler holds a wrong value, a strobe arrives early or late. This shows within one period of the affected domain after the restart, at most 48 base cycles. A wrong table entry or a wrong field position shows as a wrong repeat interval on the strobe and, for the peripheral field, as a wrong value on `per_div` in the very cycle after the write. A missed restart leaves a strobe high in the cycle after a write, and a wrong change comparison flips `per_chg` in that same cycle.

// File: rtl/clkratio_pkg.sv
package clkratio_pkg;

  localparam int CTRL_W      = 16;
  localparam int FIELD_W     = 3;
  localparam int CORE_LSB    = 6;
  localparam int BUS_LSB     = 3;
  localparam int PER_LSB     = 0;
  localparam int FAST_BIT    = 10;
  localparam int MAX_RATIO   = 8;
  localparam int SLOW_PRE    = 6;
  localparam int RATIO_W     = $clog2(MAX_RATIO + 1);
  localparam int PHASE_W     = $clog2(MAX_RATIO);
  localparam int DIV_W       = $clog2(MAX_RATIO * SLOW_PRE + 1);
  localparam int NUM_DOM     = 3;
  localparam int DOM_CORE    = 0;
  localparam int DOM_BUS     = 1;
  localparam int DOM_PER     = 2;

  typedef logic [CTRL_W-1:0]  ctrl_t;
  typedef logic [FIELD_W-1:0] code_t;
  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [DIV_W-1:0]   div_t;

  // Core and bus share one map: linear up to five, then saturate.
  function automatic ratio_t fast_ratio(input code_t code);
    ratio_t r;
    case (code)
      3'd0:    r = ratio_t'(1);
      3'd1:    r = ratio_t'(2);
      3'd2:    r = ratio_t'(3);
      3'd3:    r = ratio_t'(4);
      3'd4:    r = ratio_t'(5);
      default: r = ratio_t'(MAX_RATIO);
    endcase
    return r;
  endfunction

  // Peripheral map: starts at two, saturates from code four.
  function automatic ratio_t per_ratio(input code_t code);
    ratio_t r;
    case (code)
      3'd0:    r = ratio_t'(2);
      3'd1:    r = ratio_t'(3);
      3'd2:    r = ratio_t'(4);
      3'd3:    r = ratio_t'(6);
      default: r = ratio_t'(MAX_RATIO);
    endcase
    return r;
  endfunction

  function automatic div_t total_div(input logic fast, input ratio_t r);
    div_t d;
    if (fast) d = div_t'(r);
    else      d = div_t'(r) * div_t'(SLOW_PRE);
    return d;
  endfunction

endpackage

// File: rtl/clkratio_ctrl.sv
module clkratio_ctrl
  import clkratio_pkg::*;
#(
  parameter int    ADDR_W    = 4,
  parameter int    CTRL_ADDR = 0,
  parameter ctrl_t RESET_VAL = 16'h0E0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  ctrl_t             wr_data,
  output ctrl_t             ctrl_q,
  output logic              restart,
  output logic              per_chg,
  output div_t              per_div
);

  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(CTRL_ADDR);

  ctrl_t ctrl_r, ctrl_d;
  logic  restart_r, restart_d;
  logic  chg_r, chg_d;
  logic  accept;
  div_t  cur_div, new_div;

  assign accept  = wr_en && (wr_addr == MY_ADDR);
  assign cur_div = total_div(ctrl_r[FAST_BIT],
                             per_ratio(ctrl_r[PER_LSB +: FIELD_W]));
  assign new_div = total_div(wr_data[FAST_BIT],
                             per_ratio(wr_data[PER_LSB +: FIELD_W]));

  always_comb begin
    ctrl_d    = ctrl_r;
    restart_d = 1'b0;
    chg_d     = 1'b0;
    if (accept) begin
      ctrl_d    = wr_data;
      restart_d = 1'b1;
      chg_d     = (new_div != cur_div);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r    <= RESET_VAL;
      restart_r <= 1'b0;
      chg_r     <= 1'b0;
    end else begin
      ctrl_r    <= ctrl_d;
      restart_r <= restart_d;
      chg_r     <= chg_d;
    end
  end

  assign ctrl_q  = ctrl_r;
  assign restart = restart_r;
  assign per_chg = chg_r;
  assign per_div = cur_div;

endmodule

// File: rtl/clkratio_prescale.sv
module clkratio_prescale
  import clkratio_pkg::*;
#(
  parameter int PRE = SLOW_PRE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic fast,
  output logic tick
);

  localparam int                CNT_W = (PRE > 1) ? $clog2(PRE) : 1;
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(PRE - 1);

  logic [CNT_W-1:0] cnt_r, cnt_d;

  assign tick = fast || (cnt_r == LAST);

  always_comb begin
    cnt_d = cnt_r;
    if (restart || fast || tick) cnt_d = '0;
    else                         cnt_d = cnt_r + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_r <= '0;
    else        cnt_r <= cnt_d;
  end

endmodule

// File: rtl/clkratio_div.sv
module clkratio_div
  import clkratio_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   restart,
  input  logic   tick,
  input  ratio_t ratio,
  output logic   en
);

  logic [PHASE_W-1:0] ph_r, ph_d;
  logic               hit;

  assign hit = tick && ({{(RATIO_W-PHASE_W){1'b0}}, ph_r} == (ratio - ratio_t'(1)));
  assign en  = hit && !restart;

  always_comb begin
    ph_d = ph_r;
    if (restart)   ph_d = '0;
    else if (hit)  ph_d = '0;
    else if (tick) ph_d = ph_r + PHASE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_r <= '0;
    else        ph_r <= ph_d;
  end

endmodule

// File: rtl/clkratio_gen.sv
module clkratio_gen
  import clkratio_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter int                CTRL_ADDR = 0,
  parameter logic [15:0]       RESET_VAL = 16'h0E0A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       ctrl_q,
  output logic              core_en,
  output logic              bus_en,
  output logic              per_en,
  output logic [5:0]        per_div,
  output logic              per_chg
);

  ctrl_t              ctrl;
  logic               restart;
  logic               tick;
  div_t               pdiv;
  ratio_t             dom_ratio [NUM_DOM];
  logic [NUM_DOM-1:0] dom_en;

  clkratio_ctrl #(
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .RESET_VAL (RESET_VAL)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl_q  (ctrl),
    .restart (restart),
    .per_chg (per_chg),
    .per_div (pdiv)
  );

  clkratio_prescale #(.PRE(SLOW_PRE)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .fast    (ctrl[FAST_BIT]),
    .tick    (tick)
  );

  assign dom_ratio[DOM_CORE] = fast_ratio(ctrl[CORE_LSB +: FIELD_W]);
  assign dom_ratio[DOM_BUS]  = fast_ratio(ctrl[BUS_LSB  +: FIELD_W]);
  assign dom_ratio[DOM_PER]  = per_ratio (ctrl[PER_LSB  +: FIELD_W]);

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_dom
    clkratio_div u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick),
      .ratio   (dom_ratio[g]),
      .en      (dom_en[g])
    );
  end

  assign ctrl_q  = ctrl;
  assign core_en = dom_en[DOM_CORE];
  assign bus_en  = dom_en[DOM_BUS];
  assign per_en  = dom_en[DOM_PER];
  assign per_div = pdiv;

endmodule

// File: rtl/clkratio_chk.sv
module clkratio_chk
  import clkratio_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [15:0]       wr_data,
  input logic [15:0]       ctrl_q,
  input logic              core_en,
  input logic              bus_en,
  input logic              per_en,
  input logic [5:0]        per_div,
  input logic              per_chg
);

  logic accept;
  assign accept = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

  p_write_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ctrl_q == $past(wr_data));

  p_other_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !accept) |=> $stable(ctrl_q));

  p_restart_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !(core_en || bus_en || per_en));

  p_chg_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    per_chg |-> $past(accept));

  p_per_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    per_en |=> !per_en);

  p_core_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(accept) && ctrl_q[FAST_BIT] && ctrl_q[CORE_LSB +: FIELD_W] == 3'd0) |-> core_en);

  p_slow_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[FAST_BIT] && core_en && !accept) |=> !core_en);

  p_div_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (per_div >= 6'd2) && (per_div <= 6'd48));

endmodule

bind clkratio_gen clkratio_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .ctrl_q  (ctrl_q),
  .core_en (core_en),
  .bus_en  (bus_en),
  .per_en  (per_en),
  .per_div (per_div),
  .per_chg (per_chg)
);

// File: tb/sim_clkratio_gen.sv
`timescale 1ns/1ps
module sim_clkratio_gen;

  localparam int ADDR_W = 4;
  localparam int WIN    = 100;
  localparam int NVEC   = 7;

  logic              clk;
  logic              rst_n;
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [15:0]       wr_data;
  logic [15:0]       ctrl_q;
  logic              core_en, bus_en, per_en, per_chg;
  logic [5:0]        per_div;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // {control word, core period, bus period, peripheral period, change flag}
  localparam logic [47:0] VECS [NVEC] = '{
    {16'h04A3, 8'd3,  8'd5,  8'd6,  8'd1},
    {16'h0058, 8'd12, 8'd24, 8'd12, 8'd1},
    {16'h057C, 8'd8,  8'd8,  8'd8,  8'd1},
    {16'h05B7, 8'd8,  8'd8,  8'd8,  8'd0},
    {16'h0401, 8'd1,  8'd1,  8'd3,  8'd1},
    {16'h01D5, 8'd48, 8'd18, 8'd48, 8'd1},
    {16'hF401, 8'd1,  8'd1,  8'd3,  8'd1}
  };

  clkratio_gen #(.ADDR_W(ADDR_W)) u0 (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_q),
    .core_en (core_en),
    .bus_en  (bus_en),
    .per_en  (per_en),
    .per_div (per_div),
    .per_chg (per_chg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Window starts with counters at zero: the pulse of period p is due in cycles k with (k+1)%p==0.
  task automatic measure(input int pc, input int pb, input int pp, input string tag);
    int mc, mb, mp;
    mc = 0; mb = 0; mp = 0;
    for (int k = 0; k < WIN; k++) begin
      @(negedge clk);
      if (core_en !== (((k + 1) % pc) == 0)) mc++;
      if (bus_en  !== (((k + 1) % pb) == 0)) mb++;
      if (per_en  !== (((k + 1) % pp) == 0)) mp++;
    end
    check({"R3 R6 R7 core ", tag}, mc, 0);
    check({"R4 R6 R7 bus ",  tag}, mb, 0);
    check({"R5 R6 R7 per ",  tag}, mp, 0);
  endtask

  task automatic write(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
    @(posedge clk);
    #1;
    wr_en   = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin : stim
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset ctrl", ctrl_q, 32'h0E0A);
    check("R9 reset per_div", per_div, 32'd4);
    rst_n = 1'b1;
    measure(1, 2, 4, "after reset R1");

    for (int v = 0; v < NVEC; v++) begin
      write('0, VECS[v][47:32]);
      @(negedge clk);
      check("R2 readback", ctrl_q, VECS[v][47:32]);
      check("R9 per_div", per_div, VECS[v][15:8]);
      check("R8 per_chg", per_chg, VECS[v][0]);
      check("R7 quiet after write", {core_en, bus_en, per_en}, 3'b000);
      measure(VECS[v][31:24], VECS[v][23:16], VECS[v][15:8], $sformatf("vec%0d", v));
    end

    // R2: write to a foreign address leaves state and phase alone (core ratio 1 keeps pulsing)
    write(4'd5, 16'h0000);
    @(negedge clk);
    check("R2 foreign ctrl", ctrl_q, 32'hF401);
    check("R2 foreign no restart", core_en, 1'b1);
    check("R8 foreign no chg", per_chg, 1'b0);
    check("R9 foreign per_div", per_div, 32'd3);

    // R8: same value again restarts phases but reports no change
    write('0, 16'hF401);
    @(negedge clk);
    check("R8 same value no chg", per_chg, 1'b0);
    check("R7 same value quiet", {core_en, bus_en, per_en}, 3'b000);
    measure(1, 1, 3, "rewrite");

    // R6: fast bit alone toggled changes peripheral total divide 3 -> 18
    write('0, 16'hF001);
    @(negedge clk);
    check("R6 R8 fast bit chg", per_chg, 1'b1);
    check("R6 R9 slow per_div", per_div, 32'd18);
    measure(6, 6, 18, "slow");

    done = 1;
    summary();
  end

endmodule